// File: doc/BRIEF.md
# I2C Slave Front End for a Graphic Display Controller

This block is the serial entry point of a small graphic display controller. It watches a two-wire I2C bus (clock and data) from its own system clock. It detects START and STOP, and it accepts a transfer only when the first byte carries its seven-bit slave address. The lowest address bit is taken from a strap pin, so two controllers can share one bus.

In write transfers the byte after the address is a control byte. The control byte decides whether the following payload goes to the command register port or to the display RAM port. Each payload byte appears on one of two byte-wide outputs with a one-cycle strobe. In read transfers the block shifts out an eight-bit status word that comes from the rest of the controller.

The acknowledge is driven on its own open-drain style output, which means "pull the line low". A board may leave that output unconnected, so the block never reads back its own acknowledge to make a decision.

Top module: `dispI2cFront`

## Requirements
- R1: The first byte after a START is accepted when bits 7..1 equal 0,1,1,1,1,0 followed by the `addrSel` strap value. The block then drives `sdaDriveLow` high during the ninth clock of that byte.
- R2: On an address mismatch the block gives no acknowledge, emits no strobe and keeps `sdaDriveLow` low for every byte until the next START.
- R3: Bit 0 of a matched address byte selects the mode: 0 selects write and 1 selects read-status. In read-status mode no command or RAM strobe is produced.
- R4: In write mode the byte after the address is a control byte, and every accepted byte is acknowledged. If control bit 6 is 0, payload bytes go to the command port. If control bit 6 is 1, payload bytes go to the RAM port.
- R5: Control bit 7 is a continuation flag. When it is 1, exactly one payload byte follows and the next byte is read as a new control byte. When it is 0, every later byte keeps the current routing, whatever its value, until STOP or START.
- R6: Each payload byte raises exactly one of `cmdValid` or `ramValid` for a single clock cycle, with the received byte on the matching byte output.
- R7: In read-status mode `statusIn` is shifted out MSB first and is sampled again for each byte. A master acknowledge (data low in the ninth clock) continues the read. A master NACK ends it, and the data line stays released until the next START.
- R8: A STOP in the middle of a byte drops the partial byte and returns the block to idle. A repeated START at any point restarts the address phase.
- R9: Write transfers, and the acknowledge on `sdaDriveLow`, work the same whether or not `sdaDriveLow` is fed back into the data input.
- R10: While reset is active, and right after it, `sdaDriveLow`, `cmdValid` and `ramValid` are low.
- R11: `sdaDriveLow` only starts pulling the line low while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock as seen at the pad |
| sdaIn | input | 1 | Bus data as seen at the pad |
| addrSel | input | 1 | Strap that sets the lowest slave address bit |
| statusIn | input | 8 | Status word returned in read-status mode |
| sdaDriveLow | output | 1 | 1 pulls the data line low (acknowledge or read bit) |
| cmdValid | output | 1 | One-cycle strobe for a command byte |
| cmdByte | output | 8 | Command byte, valid with `cmdValid` |
| ramValid | output | 1 | One-cycle strobe for a display RAM byte |
| ramByte | output | 8 | RAM data byte, valid with `ramValid` |

## Verification
The assertions assume that every low and high phase of the bus clock is much longer than the two-stage synchroniser plus edge detector. They also assume that the master changes the data line only while the clock is low, apart from START and STOP. Under these assumptions an acknowledge or read bit begins in the clock-low phase in which it was decided. Payload bytes are also at least nine bus clocks apart, so each strobe lasts one cycle. The stimulus holds every quarter bit phase for eight system clocks and changes data only a quarter phase after a clock fall. It never issues STOP while the block is pulling the line low.

// File: rtl/dispI2cPkg.sv
package dispI2cPkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic cntClr;
    logic txLoad;
    logic txShift;
    logic emitCmd;
    logic emitRam;
  } dpCtrl_t;

  // Events and values from the datapath to the control FSM.
  typedef struct packed {
    logic              sclRise;
    logic              sclFall;
    logic              startDet;
    logic              stopDet;
    logic              byteFull;
    logic              sdaNow;
    logic              txNextBit;
    logic              statusMsb;
    logic [BYTE_W-1:0] rxByte;
  } dpEvt_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_CTRL, PH_DATA, PH_READ, PH_SKIP
  } phase_t;
endpackage

// File: rtl/dispI2cSync.sv
module dispI2cSync #(
  parameter int STAGES = 2,
  parameter bit IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{IDLE_VAL}};
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/dispI2cDatapath.sv
module dispI2cDatapath
  import dispI2cPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [BYTE_W-1:0] statusIn,
  input  dpCtrl_t           ctrl,
  output dpEvt_t            evt,
  output logic              cmdValid,
  output logic [BYTE_W-1:0] cmdByte,
  output logic              ramValid,
  output logic [BYTE_W-1:0] ramByte
);
  localparam int NUM_LINES = 2;

  logic [NUM_LINES-1:0] rawLines, syncLines;
  logic sclS, sdaS, sclD, sdaD;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] rxShift, txReg;

  assign rawLines = {sclIn, sdaIn};

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_sync
    dispI2cSync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sync (
      .clk (clk),
      .rstN(rstN),
      .din (rawLines[g]),
      .dout(syncLines[g])
    );
  end

  assign sclS = syncLines[1];
  assign sdaS = syncLines[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  always_comb begin
    evt.sclRise   = sclS & ~sclD;
    evt.sclFall   = ~sclS & sclD;
    evt.startDet  = sclS & sclD & sdaD & ~sdaS;
    evt.stopDet   = sclS & sclD & ~sdaD & sdaS;
    evt.byteFull  = (bitCnt == CNT_W'(BYTE_W));
    evt.sdaNow    = sdaS;
    evt.txNextBit = txReg[BYTE_W-2];
    evt.statusMsb = statusIn[BYTE_W-1];
    evt.rxByte    = rxShift;
  end

  // Bit counter and receive shifter: one bit per rising bus clock.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxShift <= '0;
    end else if (ctrl.cntClr) begin
      bitCnt <= '0;
    end else if (evt.sclRise && !evt.byteFull) begin
      bitCnt  <= bitCnt + 1'b1;
      rxShift <= {rxShift[BYTE_W-2:0], sdaS};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             txReg <= '0;
    else if (ctrl.txLoad)  txReg <= statusIn;
    else if (ctrl.txShift) txReg <= {txReg[BYTE_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      ramValid <= 1'b0;
      cmdByte  <= '0;
      ramByte  <= '0;
    end else begin
      cmdValid <= ctrl.emitCmd;
      ramValid <= ctrl.emitRam;
      if (ctrl.emitCmd) cmdByte <= rxShift;
      if (ctrl.emitRam) ramByte <= rxShift;
    end
  end
endmodule

// File: rtl/dispI2cControl.sv
module dispI2cControl
  import dispI2cPkg::*;
#(
  parameter logic [5:0] ADDR_PREFIX = 6'b011110
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    addrSel,
  input  dpEvt_t  evt,
  output dpCtrl_t ctrl,
  output logic    sdaDriveLow
);
  phase_t phase, phaseN;
  logic ackSlot, ackSlotN;
  logic rdMode, rdModeN;
  logic contFlag, contFlagN;
  logic routeRam, routeRamN;
  logic lowN;

  always_comb begin
    phaseN    = phase;
    ackSlotN  = ackSlot;
    rdModeN   = rdMode;
    contFlagN = contFlag;
    routeRamN = routeRam;
    lowN      = sdaDriveLow;
    ctrl      = '0;

    if (evt.startDet) begin
      phaseN      = PH_ADDR;
      ackSlotN    = 1'b0;
      lowN        = 1'b0;
      ctrl.cntClr = 1'b1;
    end else if (evt.stopDet) begin
      phaseN      = PH_IDLE;
      ackSlotN    = 1'b0;
      lowN        = 1'b0;
      ctrl.cntClr = 1'b1;
    end else begin
      unique case (phase)
        PH_ADDR, PH_CTRL, PH_DATA: begin
          if (evt.sclFall && !ackSlot && evt.byteFull) begin
            lowN     = 1'b1;
            ackSlotN = 1'b1;
            if (phase == PH_ADDR) begin
              if (evt.rxByte[7:1] == {ADDR_PREFIX, addrSel}) begin
                rdModeN = evt.rxByte[0];
              end else begin
                phaseN   = PH_SKIP;
                lowN     = 1'b0;
                ackSlotN = 1'b0;
              end
            end else if (phase == PH_CTRL) begin
              contFlagN = evt.rxByte[7];
              routeRamN = evt.rxByte[6];
            end else begin
              ctrl.emitCmd = ~routeRam;
              ctrl.emitRam = routeRam;
            end
          end else if (evt.sclFall && ackSlot) begin
            ackSlotN    = 1'b0;
            lowN        = 1'b0;
            ctrl.cntClr = 1'b1;
            if (phase == PH_ADDR) begin
              if (rdMode) begin
                phaseN      = PH_READ;
                ctrl.txLoad = 1'b1;
                lowN        = ~evt.statusMsb;
              end else begin
                phaseN = PH_CTRL;
              end
            end else if (phase == PH_CTRL) begin
              phaseN = PH_DATA;
            end else begin
              phaseN = contFlag ? PH_CTRL : PH_DATA;
            end
          end
        end
        PH_READ: begin
          if (!ackSlot) begin
            if (evt.sclFall) begin
              if (evt.byteFull) begin
                lowN     = 1'b0;
                ackSlotN = 1'b1;
              end else begin
                ctrl.txShift = 1'b1;
                lowN         = ~evt.txNextBit;
              end
            end
          end else if (evt.sclRise && evt.sdaNow) begin
            phaseN   = PH_SKIP;
            ackSlotN = 1'b0;
          end else if (evt.sclFall) begin
            ackSlotN    = 1'b0;
            ctrl.cntClr = 1'b1;
            ctrl.txLoad = 1'b1;
            lowN        = ~evt.statusMsb;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase       <= PH_IDLE;
      ackSlot     <= 1'b0;
      rdMode      <= 1'b0;
      contFlag    <= 1'b0;
      routeRam    <= 1'b0;
      sdaDriveLow <= 1'b0;
    end else begin
      phase       <= phaseN;
      ackSlot     <= ackSlotN;
      rdMode      <= rdModeN;
      contFlag    <= contFlagN;
      routeRam    <= routeRamN;
      sdaDriveLow <= lowN;
    end
  end
endmodule

// File: rtl/dispI2cFront.sv
module dispI2cFront
  import dispI2cPkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] ADDR_PREFIX = 6'b011110
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              addrSel,
  input  logic [BYTE_W-1:0] statusIn,
  output logic              sdaDriveLow,
  output logic              cmdValid,
  output logic [BYTE_W-1:0] cmdByte,
  output logic              ramValid,
  output logic [BYTE_W-1:0] ramByte
);
  dpCtrl_t ctrl;
  dpEvt_t  evt;

  dispI2cDatapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .statusIn(statusIn),
    .ctrl    (ctrl),
    .evt     (evt),
    .cmdValid(cmdValid),
    .cmdByte (cmdByte),
    .ramValid(ramValid),
    .ramByte (ramByte)
  );

  dispI2cControl #(.ADDR_PREFIX(ADDR_PREFIX)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .addrSel    (addrSel),
    .evt        (evt),
    .ctrl       (ctrl),
    .sdaDriveLow(sdaDriveLow)
  );
endmodule

// File: rtl/dispI2cFrontChk.sv
module dispI2cFrontChk (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaDriveLow,
  input logic cmdValid,
  input logic ramValid
);
  // R6: the two payload ports never fire together.
  p_one_port_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && ramValid));

  // R6: each command strobe lasts one cycle.
  p_cmd_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  // R6: each RAM strobe lasts one cycle.
  p_ram_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    ramValid |=> !ramValid);

  // R4: a command byte is only delivered together with its acknowledge.
  p_cmd_acked_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> sdaDriveLow);

  // R4: a RAM byte is only delivered together with its acknowledge.
  p_ram_acked_r4: assert property (@(posedge clk) disable iff (!rstN)
    ramValid |-> sdaDriveLow);

  // R11: pulling the line low only begins while the bus clock is low.
  p_drive_scl_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> !sclIn);
endmodule

bind dispI2cFront dispI2cFrontChk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sclIn      (sclIn),
  .sdaDriveLow(sdaDriveLow),
  .cmdValid   (cmdValid),
  .ramValid   (ramValid)
);

// File: tb/tb_dispI2cFront.sv
module tb_dispI2cFront;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic ackWired = 1'b1;
  logic addrSel = 1'b0;
  logic [7:0] statusIn = 8'h00;
  logic sdaIn;
  logic sdaDriveLow, cmdValid, ramValid;
  logic [7:0] cmdByte, ramByte;

  int total = 0;
  int bad = 0;
  logic [7:0] cmdLog [64];
  logic [7:0] ramLog [64];
  int cmdCnt = 0;
  int ramCnt = 0;

  always #5 clk = ~clk;

  // Wired-AND bus model; the acknowledge output may be left unconnected.
  assign sdaIn = sdaM & (ackWired ? ~sdaDriveLow : 1'b1);

  dispI2cFront dut (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclM),
    .sdaIn      (sdaIn),
    .addrSel    (addrSel),
    .statusIn   (statusIn),
    .sdaDriveLow(sdaDriveLow),
    .cmdValid   (cmdValid),
    .cmdByte    (cmdByte),
    .ramValid   (ramValid),
    .ramByte    (ramByte)
  );

  always @(posedge clk) begin
    if (cmdValid) begin cmdLog[cmdCnt % 64] <= cmdByte; cmdCnt <= cmdCnt + 1; end
    if (ramValid) begin ramLog[ramCnt % 64] <= ramByte; ramCnt <= ramCnt + 1; end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(1);
    sclM = 1'b1; waitQ(2);
    sdaM = 1'b0; waitQ(2);
    sclM = 1'b0; waitQ(1);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(1);
    sclM = 1'b1; waitQ(2);
    sdaM = 1'b1; waitQ(2);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i]; waitQ(1);
      sclM = 1'b1; waitQ(2);
      sclM = 1'b0; waitQ(1);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    sendBits(b, 8);
    sdaM = 1'b1; waitQ(1);
    sclM = 1'b1; waitQ(1);
    acked = sdaDriveLow;
    waitQ(1);
    sclM = 1'b0; waitQ(1);
  endtask

  task automatic readByte(input logic masterAck, input logic [7:0] nextStatus,
                          output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1'b1; waitQ(1);
      sclM = 1'b1; waitQ(1);
      b[i] = ~sdaDriveLow;
      waitQ(1);
      sclM = 1'b0; waitQ(1);
    end
    statusIn = nextStatus;
    sdaM = ~masterAck; waitQ(1);
    sclM = 1'b1; waitQ(2);
    sclM = 1'b0; waitQ(1);
    sdaM = 1'b1;
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check(sdaDriveLow == 1'b0, "R10 drive in reset", sdaDriveLow, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(cmdValid == 1'b0, "R10 cmdValid after reset", cmdValid, 0);
    check(ramValid == 1'b0, "R10 ramValid after reset", ramValid, 0);
    check(sdaDriveLow == 1'b0, "R10 drive after reset", sdaDriveLow, 0);
  endtask

  task automatic testCommandPath();
    logic a;
    int c0 = cmdCnt, r0 = ramCnt;
    addrSel = 1'b0;
    busStart();
    sendByte(8'h78, a); check(a == 1'b1, "R1 address ack strap0", a, 1);
    sendByte(8'h00, a); check(a == 1'b1, "R4 control ack", a, 1);
    sendByte(8'hA5, a); check(a == 1'b1, "R4 command ack", a, 1);
    sendByte(8'h3C, a);
    busStop();
    check(cmdCnt - c0 == 2, "R4 command count", cmdCnt - c0, 2);
    check(cmdLog[c0 % 64] == 8'hA5, "R6 command byte 0", cmdLog[c0 % 64], 8'hA5);
    check(cmdLog[(c0 + 1) % 64] == 8'h3C, "R6 command byte 1", cmdLog[(c0 + 1) % 64], 8'h3C);
    check(ramCnt == r0, "R4 no RAM on command route", ramCnt - r0, 0);
  endtask

  task automatic testRamPath();
    logic a;
    int c0 = cmdCnt, r0 = ramCnt;
    addrSel = 1'b1;
    busStart();
    sendByte(8'h7A, a); check(a == 1'b1, "R1 address ack strap1", a, 1);
    sendByte(8'h40, a);
    sendByte(8'h11, a);
    sendByte(8'hC5, a);
    sendByte(8'h33, a);
    busStop();
    check(ramCnt - r0 == 3, "R5 RAM count with flag clear", ramCnt - r0, 3);
    check(ramLog[(r0 + 1) % 64] == 8'hC5, "R5 byte kept as data", ramLog[(r0 + 1) % 64], 8'hC5);
    check(ramLog[(r0 + 2) % 64] == 8'h33, "R4 RAM byte", ramLog[(r0 + 2) % 64], 8'h33);
    check(cmdCnt == c0, "R4 no command on RAM route", cmdCnt - c0, 0);
  endtask

  task automatic testMismatch();
    logic a;
    int c0 = cmdCnt, r0 = ramCnt;
    addrSel = 1'b0;
    busStart();
    sendByte(8'h7A, a); check(a == 1'b0, "R2 strap mismatch no ack", a, 0);
    sendByte(8'h00, a); check(a == 1'b0, "R2 later byte no ack", a, 0);
    sendByte(8'h55, a); check(a == 1'b0, "R2 payload no ack", a, 0);
    busStop();
    busStart();
    sendByte(8'hF8, a); check(a == 1'b0, "R2 prefix mismatch no ack", a, 0);
    sendByte(8'h40, a);
    sendByte(8'h66, a);
    busStop();
    check(cmdCnt == c0 && ramCnt == r0, "R2 no strobes", cmdCnt - c0 + ramCnt - r0, 0);
  endtask

  task automatic testContinuation();
    logic a;
    int c0 = cmdCnt, r0 = ramCnt;
    addrSel = 1'b0;
    busStart();
    sendByte(8'h78, a);
    sendByte(8'h80, a);
    sendByte(8'h11, a);
    sendByte(8'hC0, a);
    sendByte(8'h22, a);
    sendByte(8'h00, a);
    sendByte(8'h33, a);
    sendByte(8'h44, a);
    busStop();
    check(cmdCnt - c0 == 3, "R5 command count", cmdCnt - c0, 3);
    check(cmdLog[c0 % 64] == 8'h11, "R5 single command", cmdLog[c0 % 64], 8'h11);
    check(cmdLog[(c0 + 2) % 64] == 8'h44, "R5 trailing command", cmdLog[(c0 + 2) % 64], 8'h44);
    check(ramCnt - r0 == 1, "R5 RAM count", ramCnt - r0, 1);
    check(ramLog[r0 % 64] == 8'h22, "R5 single RAM byte", ramLog[r0 % 64], 8'h22);
  endtask

  task automatic testRead();
    logic a;
    logic [7:0] b;
    int c0 = cmdCnt, r0 = ramCnt;
    addrSel = 1'b1;
    statusIn = 8'hA6;
    busStart();
    sendByte(8'h7B, a); check(a == 1'b1, "R3 read address ack", a, 1);
    readByte(1'b1, 8'h5B, b); check(b == 8'hA6, "R7 first status", b, 8'hA6);
    readByte(1'b0, 8'h00, b); check(b == 8'h5B, "R7 resampled status", b, 8'h5B);
    readByte(1'b0, 8'h00, b); check(b == 8'hFF, "R7 released after NACK", b, 8'hFF);
    busStop();
    check(cmdCnt == c0 && ramCnt == r0, "R3 no strobes in read", cmdCnt - c0 + ramCnt - r0, 0);
  endtask

  task automatic testAbort();
    logic a;
    int c0 = cmdCnt, r0 = ramCnt;
    addrSel = 1'b0;
    busStart();
    sendByte(8'h78, a);
    sendByte(8'h40, a);
    sendBits(8'hFF, 4);
    busStop();
    check(ramCnt == r0, "R8 partial byte dropped", ramCnt - r0, 0);
    busStart();
    sendByte(8'h78, a);
    sendByte(8'h00, a);
    sendByte(8'h9A, a);
    busStart();
    sendByte(8'h78, a); check(a == 1'b1, "R8 repeated start address", a, 1);
    sendByte(8'h40, a);
    sendByte(8'h77, a);
    busStop();
    check(cmdCnt - c0 == 1 && cmdLog[c0 % 64] == 8'h9A, "R8 command before restart",
          cmdLog[c0 % 64], 8'h9A);
    check(ramCnt - r0 == 1 && ramLog[r0 % 64] == 8'h77, "R8 RAM after restart",
          ramLog[r0 % 64], 8'h77);
  endtask

  task automatic testUnwired();
    logic a;
    int c0 = cmdCnt;
    ackWired = 1'b0;
    addrSel = 1'b0;
    busStart();
    sendByte(8'h78, a); check(a == 1'b1, "R9 ack with open output", a, 1);
    sendByte(8'h00, a);
    sendByte(8'h5E, a); check(a == 1'b1, "R9 payload ack open output", a, 1);
    busStop();
    check(cmdCnt - c0 == 1 && cmdLog[c0 % 64] == 8'h5E, "R9 command delivered",
          cmdLog[c0 % 64], 8'h5E);
    ackWired = 1'b1;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    testReset();
    testCommandPath();
    testRamPath();
    testMismatch();
    testContinuation();
    testRead();
    testAbort();
    testUnwired();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule